// File: doc/BRIEF.md
# VPS Biphase Nibble Decoder

This block turns a sampled VPS payload back into data bytes. The payload reaches it as a stream of bytes, where each byte holds four two-chip biphase cells. Each byte therefore yields one nibble. Consecutive input bytes are paired into one output byte: the first byte of the pair gives the upper nibble and the second gives the lower nibble. A full packet is 26 input bytes, which become 13 output bytes.

Every chip cell is checked for a legal transition. An illegal cell raises its own flag next to the output byte it belongs to. All flags in a packet are also ORed into a sticky packet error, which can be read as soon as the packet completes.

The upstream logic marks the first byte of a packet with a start pulse and every byte with a valid strobe. It can pause between bytes for any number of cycles. Finding the packet inside a video line and parsing the header that wraps it are handled outside this block.

Top module: `vps_biphase_dec`

## Requirements
- R1: While reset is active and in the first cycle after it, `out_valid`, `pkt_done` and `pkt_err` are low.
- R2: The cell at input bits [2i+1:2i] (i = 0..3) decodes into nibble bit 3-i. Cell value 2'b01 decodes to 1 and 2'b10 decodes to 0. For example, 8'hA9 decodes to 4'h8 and 8'h6A decodes to 4'h1.
- R3: A cell of 2'b00 or 2'b11 is illegal. It sets the chip error flag at the nibble position of that cell, and its data bit reads 0. For example, 8'hA8 gives nibble 0 with error 4'h8.
- R4: Within a pair, the first accepted byte fills `out_byte[7:4]` and `out_chip_err[7:4]`. The second fills `out_byte[3:0]` and `out_chip_err[3:0]`.
- R5: `out_valid` is high for exactly one cycle, in the cycle after the second byte of a pair is accepted. It stays low after the first byte of a pair.
- R6: A packet is 26 accepted bytes, which produce 13 output bytes. `pkt_done` goes high in the cycle after the 26th byte is accepted, at the same time as the last `out_valid`. It stays high until the next start.
- R7: `pkt_err` is the OR of every chip error flag from all bytes of the packet. It holds its value until the next start, and it is valid when `pkt_done` rises.
- R8: A start clears `pkt_done`, `pkt_err`, the byte position and any half-finished pair. A byte that arrives together with start is byte 0 of the new packet, and its chip errors count toward the new `pkt_err`.
- R9: After the 26th byte and before the next start, valid bytes are ignored. No `out_valid` is produced, and `pkt_done` and `pkt_err` do not change.
- R10: Cycles with `in_valid` low consume nothing and produce no output, so gaps between bytes do not change the result.
- R11: After reset, valid bytes are ignored until the first start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_start | input | 1 | Begins a new packet; the byte in the same cycle, if valid, is byte 0 |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Four biphase cells |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Decoded byte |
| out_chip_err | output | 8 | Illegal-cell flags, one per bit of `out_byte` |
| pkt_done | output | 1 | Packet complete |
| pkt_err | output | 1 | Sticky packet error |

## Verification
Two events can fall in the same cycle: a start that clears the sticky error, and an accepted byte that sets it. The bench provokes this by sending a start together with an all-illegal byte, then finishing the packet with clean bytes. `pkt_err` must read 1 at completion.

The bench also sends a start in the same cycle as the second byte of a half-finished pair. That pair must be dropped, the earlier error must be forgotten, and the output count must restart from that byte.

// File: rtl/vps_dec_pkg.sv
package vps_dec_pkg;

    localparam int CELLS_PER_BYTE = 4;
    localparam int NIB_W          = CELLS_PER_BYTE;
    localparam int BYTE_W         = 2 * CELLS_PER_BYTE;
    localparam int PAIR_OUT_W     = 2 * NIB_W;

    localparam logic [1:0] CELL_ONE  = 2'b01;
    localparam logic [1:0] CELL_ZERO = 2'b10;

    typedef struct packed {
        logic bad;
        logic bit_v;
    } cell_t;

    typedef struct packed {
        logic [NIB_W-1:0] err;
        logic [NIB_W-1:0] nib;
    } nib_dec_t;

    typedef struct packed {
        logic [PAIR_OUT_W-1:0] err;
        logic [PAIR_OUT_W-1:0] data;
    } out_word_t;

    function automatic cell_t decode_cell(input logic [1:0] chips);
        cell_t c;
        c.bit_v = (chips == CELL_ONE);
        c.bad   = (chips != CELL_ONE) && (chips != CELL_ZERO);
        return c;
    endfunction

endpackage

// File: rtl/vps_chip_decode.sv
module vps_chip_decode
    import vps_dec_pkg::*;
(
    input  logic [BYTE_W-1:0] chips,
    output nib_dec_t          dec
);

    genvar gi;
    generate
        for (gi = 0; gi < CELLS_PER_BYTE; gi++) begin : g_cell
            cell_t c;
            assign c = decode_cell(chips[2*gi+1 -: 2]);
            assign dec.nib[NIB_W-1-gi] = c.bit_v;
            assign dec.err[NIB_W-1-gi] = c.bad;
        end
    endgenerate

endmodule

// File: rtl/vps_pkt_ctrl.sv
module vps_pkt_ctrl #(
    parameter int OUT_BYTES = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic in_start,
    input  logic in_valid,
    input  logic byte_bad,
    output logic accept,
    output logic first_of_pair,
    output logic done_q,
    output logic err_q
);

    localparam int IN_BYTES = 2 * OUT_BYTES;
    localparam int IDX_W    = $clog2(IN_BYTES + 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] base;
    logic [IDX_W-1:0] idx_nxt;
    logic             active_q;
    logic             last;

    assign base          = in_start ? '0 : idx_q;
    assign accept        = in_valid && (in_start || active_q);
    assign idx_nxt       = base + 1'b1;
    assign last          = (idx_nxt == IDX_W'(IN_BYTES));
    assign first_of_pair = ~base[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            active_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            if (in_start) begin
                idx_q    <= '0;
                active_q <= 1'b1;
                done_q   <= 1'b0;
                err_q    <= 1'b0;
            end
            if (accept) begin
                idx_q <= idx_nxt;
                err_q <= (in_start ? 1'b0 : err_q) | byte_bad;
                if (last) begin
                    active_q <= 1'b0;
                    done_q   <= 1'b1;
                end
            end
        end
    end

    // R8
    start_clears_done_chk: assert property (@(posedge clk) disable iff (rst)
        in_start |=> !done_q);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !in_start) |=> err_q);

    // R9
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !active_q && !in_start) |=> ($stable(idx_q) && $stable(err_q)));

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(accept));

endmodule

// File: rtl/vps_pair_merge.sv
module vps_pair_merge
    import vps_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      first_of_pair,
    input  nib_dec_t  dec,
    output logic      vld_q,
    output out_word_t word_q
);

    nib_dec_t hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            vld_q  <= 1'b0;
            word_q <= '0;
        end else begin
            vld_q <= 1'b0;
            if (accept && first_of_pair) begin
                hi_q <= dec;
            end
            if (accept && !first_of_pair) begin
                vld_q       <= 1'b1;
                word_q.data <= {hi_q.nib, dec.nib};
                word_q.err  <= {hi_q.err, dec.err};
            end
        end
    end

    // R5
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> $past(accept && !first_of_pair));

    // R5
    out_single_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |=> !vld_q);

endmodule

// File: rtl/vps_biphase_dec.sv
module vps_biphase_dec
    import vps_dec_pkg::*;
#(
    parameter int OUT_BYTES = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_start,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic [7:0]        out_chip_err,
    output logic              pkt_done,
    output logic              pkt_err
);

    nib_dec_t  dec;
    out_word_t word;
    logic      accept;
    logic      first_of_pair;

    vps_chip_decode u_dec (
        .chips (in_byte),
        .dec   (dec)
    );

    vps_pkt_ctrl #(.OUT_BYTES(OUT_BYTES)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .in_start      (in_start),
        .in_valid      (in_valid),
        .byte_bad      (|dec.err),
        .accept        (accept),
        .first_of_pair (first_of_pair),
        .done_q        (pkt_done),
        .err_q         (pkt_err)
    );

    vps_pair_merge u_merge (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .first_of_pair (first_of_pair),
        .dec           (dec),
        .vld_q         (out_valid),
        .word_q        (word)
    );

    assign out_byte     = word.data;
    assign out_chip_err = word.err;

    // R7
    err_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (|out_chip_err)) |-> pkt_err);

endmodule

// File: tb/tb_vps_biphase_dec.sv
module tb_vps_biphase_dec;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_start;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       out_valid;
    logic [7:0] out_byte;
    logic [7:0] out_chip_err;
    logic       pkt_done;
    logic       pkt_err;

    int checks = 0;
    int fails  = 0;
    bit over   = 1'b0;

    always #2 clk = ~clk;

    vps_biphase_dec dut (
        .clk          (clk),
        .rst          (rst),
        .in_start     (in_start),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .out_valid    (out_valid),
        .out_byte     (out_byte),
        .out_chip_err (out_chip_err),
        .pkt_done     (pkt_done),
        .pkt_err      (pkt_err)
    );

    // {first byte, second byte, expected out_byte, expected out_chip_err}
    localparam logic [31:0] VEC [8] = '{
        32'hAAAA_0000,
        32'h5555_FF00,
        32'hA96A_8100,
        32'h6699_5A00,
        32'h56A9_7800,
        32'h0055_0FF0,
        32'hA8FF_008F,
        32'h5754_7788
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic st);
        in_byte  = b;
        in_valid = 1'b1;
        in_start = st;
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!over) begin
            over = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_start = 1'b0; in_valid = 1'b0; in_byte = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 done in reset", pkt_done, 0);
        rst = 1'b0;
        idle();
        chk("R1 err after reset", pkt_err, 0);
        chk("R1 done after reset", pkt_done, 0);

        // R11: no start yet
        push(8'h00, 1'b0);
        push(8'h55, 1'b0);
        chk("R11 no output before start", out_valid, 0);
        chk("R11 err before start", pkt_err, 0);

        // Table walk: one packet over the vector table, errored
        for (int k = 0; k < 13; k++) begin
            logic [31:0] v;
            v = VEC[k % 8];
            push(v[31:24], k == 0);
            chk("R5 quiet after first byte", out_valid, 0);
            if (k == 12) chk("R6 not done early", pkt_done, 0);
            push(v[23:16], 1'b0);
            chk("R5 valid after second byte", out_valid, 1);
            chk("R2 R4 data", out_byte, v[15:8]);
            chk("R3 R4 cell errors", out_chip_err, v[7:0]);
        end
        chk("R6 done after 26", pkt_done, 1);
        chk("R7 packet err", pkt_err, 1);
        idle();
        chk("R5 single pulse", out_valid, 0);

        // Clean packet with gaps
        push(VEC[0][31:24], 1'b1);
        chk("R8 start clears err", pkt_err, 0);
        chk("R8 start clears done", pkt_done, 0);
        idle();
        chk("R10 gap no output", out_valid, 0);
        push(VEC[0][23:16], 1'b0);
        chk("R10 data after gap", out_byte, VEC[0][15:8]);
        for (int k = 1; k < 13; k++) begin
            logic [31:0] v;
            v = VEC[k % 5];
            push(v[31:24], 1'b0);
            idle();
            idle();
            chk("R10 no output in gap", out_valid, 0);
            push(v[23:16], 1'b0);
            chk("R10 valid", out_valid, 1);
            chk("R2 clean data", out_byte, v[15:8]);
        end
        chk("R6 done clean", pkt_done, 1);
        chk("R7 clean err", pkt_err, 0);

        // R9: trailing bytes ignored
        push(8'h00, 1'b0);
        chk("R9 no output", out_valid, 0);
        push(8'hFF, 1'b0);
        chk("R9 no output 2", out_valid, 0);
        chk("R9 err unchanged", pkt_err, 0);
        chk("R9 done unchanged", pkt_done, 1);

        // R8: start alone, then abort a half pair
        in_start = 1'b1;
        idle();
        in_start = 1'b0;
        chk("R8 start alone clears done", pkt_done, 0);
        push(8'h00, 1'b0);
        chk("R8 half pair quiet", out_valid, 0);
        push(8'hA9, 1'b1);
        chk("R8 restart drops half pair", out_valid, 0);
        chk("R8 restart clears err", pkt_err, 0);
        push(8'h6A, 1'b0);
        chk("R8 restart pairing", out_byte, 32'h81);
        chk("R8 restart cell errors", out_chip_err, 0);
        for (int k = 1; k < 13; k++) begin
            push(8'h55, 1'b0);
            push(8'hAA, 1'b0);
        end
        chk("R8 R6 restart count", pkt_done, 1);
        chk("R8 restart packet clean", pkt_err, 0);

        // R8: start together with an illegal byte
        push(8'h00, 1'b1);
        chk("R8 start and error same cycle", pkt_err, 1);
        push(8'hAA, 1'b0);
        chk("R3 err field", out_chip_err, 32'hF0);
        for (int k = 1; k < 13; k++) begin
            push(8'hAA, 1'b0);
            push(8'h55, 1'b0);
        end
        chk("R7 err kept to done", pkt_err, 1);
        chk("R6 done", pkt_done, 1);

        finish_run();
    end

endmodule